// File: doc/BRIEF.md
# Microcontroller-to-LCD passthrough bridge

This block sits between a microcontroller's narrow parallel write port and a latched 8-bit LCD bus. While it is in passthrough mode, it collects the microcontroller's byte writes in pairs. Each pair becomes one 16-bit panel word. The bridge then plays that word out to the panel as two bytes. The high byte is caught by an external transparent latch under a latch-enable pulse. The low byte is written with an active-low write strobe. The command/data select travels with the word.

A special first byte switches the block into a second operating mode. In that mode a frame-streaming engine takes the LCD pins for itself. The bridge then drops all further microcontroller writes until the mode is left again through a one-cycle exit pulse.

The bridge decides which side drives the panel pins. It never cuts off a word that is half sent. A busy line tells the microcontroller when it may send the next bytes. The panel reset line is not handled here.

Top module: `lcd_passthru_bridge`

## Requirements
- R1: After reset the block is in passthrough mode with no half-received pair, `mcu_busy_o`=0, `sprite_mode_o`=0, `fw_grant_o`=0, `lcd_wr_n_o`=1 and `lcd_le_o`=0.
- R2: A transfer is taken on a rising edge of `mcu_wr_i` (active high), after a two-flop synchroniser. A first byte with bit 7 = 0 followed by a second byte yields the panel word {first[6:0], second[7:0], 1'b0}. Bit 15 is the MSB, and bit 0 is always 0.
- R3: The command/data level of a word (`lcd_rs_o`) is the `mcu_rs_i` level sampled with the first byte. The level sampled with the second byte has no effect.
- R4: Bit 7 of the second byte is ordinary data and never changes the mode.
- R5: A first byte with bit 7 = 1 puts the block in sprite mode at once. It produces no panel word, and the pair phase goes back to "expect first byte".
- R6: A word is played out in four phases of STEP_CYC clock cycles each. In phase 1 the high byte is driven with `lcd_le_o`=1. In phase 2 `lcd_le_o`=0 and the high byte is still held. In phase 3 the low byte is driven with `lcd_wr_n_o`=0. In phase 4 `lcd_wr_n_o`=1 and the low byte is still held. `lcd_le_o` and `lcd_wr_n_o`=0 never coincide.
- R7: `mcu_busy_o` rises once the second byte has been taken. It stays high until the word has finished on the panel bus, and it then falls.
- R8: A completed pair that arrives while a word is still being sent waits, and words reach the panel in arrival order. Write strobes that arrive while such a word is waiting are ignored.
- R9: In sprite mode, once no passthrough word is in flight or waiting, `fw_grant_o`=1 and the LCD pins follow the `fw_*` inputs. A word already in flight when the mode is entered finishes first.
- R10: In sprite mode, microcontroller write strobes are ignored, and `mcu_busy_o` follows `fw_active_i`.
- R11: A one-cycle `sprite_exit_i` pulse in sprite mode returns the block to passthrough. The pair phase is cleared, and the panel pins go back to the idle sender levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcu_data_i | input | 8 | Microcontroller byte, held while the write strobe is high |
| mcu_wr_i | input | 1 | Microcontroller write strobe, rising edge takes the byte |
| mcu_rs_i | input | 1 | Command/data level sent with the byte |
| mcu_busy_o | output | 1 | High while the microcontroller must not send |
| sprite_mode_o | output | 1 | High while the frame-streaming mode is active |
| sprite_exit_i | input | 1 | One-cycle pulse that leaves sprite mode |
| fw_active_i | input | 1 | Frame streamer is working (drives busy in sprite mode) |
| fw_grant_o | output | 1 | Frame streamer currently owns the LCD pins |
| fw_data_i | input | 8 | Frame streamer byte for the LCD bus |
| fw_le_i | input | 1 | Frame streamer latch enable |
| fw_wr_n_i | input | 1 | Frame streamer active-low write strobe |
| fw_rs_i | input | 1 | Frame streamer command/data level |
| lcd_data_o | output | 8 | LCD data bus (also feeds the high-byte latch) |
| lcd_le_o | output | 1 | Latch enable for the high byte |
| lcd_wr_n_o | output | 1 | Active-low panel write strobe |
| lcd_rs_o | output | 1 | Panel command/data select |

## Verification
Word packing is tested with byte pairs of all zeros, all ones in the payload bits, and alternating bit patterns. These separate a correct {first[6:0], second, 0} packing from shifted or swapped packings. Pairs whose first and second RS levels differ show which byte supplies RS. A second byte of 0x80 separates "escape only on the first byte" from "escape on any byte".

A burst of back-to-back pairs plus one extra byte shows that the waiting word is queued and that the stray strobe is dropped. If it were not dropped, the following pair would come out misaligned. Entering sprite mode while a word is in flight shows that the bus is handed over only after that word is done. Writes sent during sprite mode, followed by an exit and a fresh pair, show that those writes left no trace.

// File: rtl/lcd_pt_pkg.sv
package lcd_pt_pkg;

  localparam int unsigned PT_BYTE_W = 8;
  localparam int unsigned PT_WORD_W = 2 * PT_BYTE_W;

  typedef logic [PT_BYTE_W-1:0] pt_byte_t;
  typedef logic [PT_WORD_W-1:0] pt_word_t;

  // One full set of LCD-side pins
  typedef struct packed {
    pt_byte_t data;
    logic     le;
    logic     wr_n;
    logic     rs;
  } lcd_pins_t;

  typedef enum logic [2:0] {
    SND_IDLE,
    SND_HIGH,
    SND_LATCH,
    SND_STROBE,
    SND_RECOVER
  } snd_state_e;

  // Top bit of a first byte flags the mode escape
  function automatic logic is_escape(input pt_byte_t b);
    return b[PT_BYTE_W-1];
  endfunction

  // Seven payload bits of the first byte, all of the second, LSB forced low
  function automatic pt_word_t pack_word(input pt_byte_t first, input pt_byte_t second);
    return {first[PT_BYTE_W-2:0], second, 1'b0};
  endfunction

  function automatic lcd_pins_t idle_pins();
    lcd_pins_t p;
    p.data = '0;
    p.le   = 1'b0;
    p.wr_n = 1'b1;
    p.rs   = 1'b0;
    return p;
  endfunction

endpackage

// File: rtl/wr_strobe_sync.sv
module wr_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], wr_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/byte_pair_framer.sv
module byte_pair_framer
  import lcd_pt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rise_i,
  input  pt_byte_t data_i,
  input  logic     rs_i,
  input  logic     exit_i,
  input  logic     snd_busy_i,
  output logic     go_o,
  output pt_word_t word_o,
  output logic     word_rs_o,
  output logic     pend_o,
  output logic     sprite_o
);

  pt_byte_t first_q;
  logic     first_rs_q;
  logic     phase_q;     // 1: first byte held, waiting for the second
  logic     pend_q;
  logic     sprite_q;
  pt_word_t word_q;
  logic     word_rs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q    <= '0;
      first_rs_q <= 1'b0;
      phase_q    <= 1'b0;
      pend_q     <= 1'b0;
      sprite_q   <= 1'b0;
      word_q     <= '0;
      word_rs_q  <= 1'b0;
    end else begin
      if (go_o) pend_q <= 1'b0;
      if (sprite_q) begin
        if (exit_i) begin
          sprite_q <= 1'b0;
          phase_q  <= 1'b0;
        end
      end else if (rise_i && !pend_q) begin
        if (!phase_q) begin
          if (is_escape(data_i)) begin
            sprite_q <= 1'b1;
          end else begin
            first_q    <= data_i;
            first_rs_q <= rs_i;
            phase_q    <= 1'b1;
          end
        end else begin
          word_q    <= pack_word(first_q, data_i);
          word_rs_q <= first_rs_q;
          pend_q    <= 1'b1;
          phase_q   <= 1'b0;
        end
      end
    end
  end

  assign go_o      = pend_q & ~snd_busy_i;
  assign word_o    = word_q;
  assign word_rs_o = word_rs_q;
  assign pend_o    = pend_q;
  assign sprite_o  = sprite_q;

  AST_IGNORE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && pend_q) |=> (phase_q == $past(phase_q))); // R8

  AST_SPRITE_FREEZES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sprite_q && !exit_i) |=> (sprite_q && !phase_q)); // R10

endmodule

// File: rtl/latched_word_sender.sv
module latched_word_sender
  import lcd_pt_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_i,
  input  pt_word_t  word_i,
  input  logic      rs_i,
  output lcd_pins_t pins_o,
  output logic      busy_o
);

  localparam int unsigned CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);

  snd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  pt_word_t         word_q;
  logic             rs_q;

  function automatic snd_state_e next_phase(input snd_state_e s);
    case (s)
      SND_HIGH:    return SND_LATCH;
      SND_LATCH:   return SND_STROBE;
      SND_STROBE:  return SND_RECOVER;
      default:     return SND_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SND_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      rs_q    <= 1'b0;
    end else if (state_q == SND_IDLE) begin
      if (go_i) begin
        word_q  <= word_i;
        rs_q    <= rs_i;
        cnt_q   <= '0;
        state_q <= SND_HIGH;
      end
    end else if (cnt_q == CNT_LAST) begin
      cnt_q   <= '0;
      state_q <= next_phase(state_q);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    pins_o = idle_pins();
    case (state_q)
      SND_HIGH: begin
        pins_o.data = word_q[PT_WORD_W-1 -: PT_BYTE_W];
        pins_o.le   = 1'b1;
        pins_o.rs   = rs_q;
      end
      SND_LATCH: begin
        pins_o.data = word_q[PT_WORD_W-1 -: PT_BYTE_W];
        pins_o.rs   = rs_q;
      end
      SND_STROBE: begin
        pins_o.data = word_q[PT_BYTE_W-1:0];
        pins_o.wr_n = 1'b0;
        pins_o.rs   = rs_q;
      end
      SND_RECOVER: begin
        pins_o.data = word_q[PT_BYTE_W-1:0];
        pins_o.rs   = rs_q;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != SND_IDLE);

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o); // R8

  AST_LE_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_o.wr_n |-> !pins_o.le); // R6

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(word_q)); // R6

endmodule

// File: rtl/lcd_bus_mux.sv
module lcd_bus_mux
  import lcd_pt_pkg::*;
(
  input  logic      sel_fw_i,
  input  lcd_pins_t pt_i,
  input  lcd_pins_t fw_i,
  output lcd_pins_t pins_o
);

  assign pins_o = sel_fw_i ? fw_i : pt_i;

endmodule

// File: rtl/lcd_passthru_bridge.sv
module lcd_passthru_bridge
  import lcd_pt_pkg::*;
#(
  parameter int unsigned STEP_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] mcu_data_i,
  input  logic       mcu_wr_i,
  input  logic       mcu_rs_i,
  output logic       mcu_busy_o,
  output logic       sprite_mode_o,
  input  logic       sprite_exit_i,
  input  logic       fw_active_i,
  output logic       fw_grant_o,
  input  logic [7:0] fw_data_i,
  input  logic       fw_le_i,
  input  logic       fw_wr_n_i,
  input  logic       fw_rs_i,
  output logic [7:0] lcd_data_o,
  output logic       lcd_le_o,
  output logic       lcd_wr_n_o,
  output logic       lcd_rs_o
);

  // Named internal events
  logic      wr_rise;
  logic      snd_go;
  logic      snd_busy;
  logic      word_pend;
  logic      sprite_on;
  logic      sel_fw;
  pt_word_t  pair_word;
  logic      pair_rs;
  lcd_pins_t snd_pins;
  lcd_pins_t fw_pins;
  lcd_pins_t out_pins;

  wr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mcu_wr_i),
    .rise_o (wr_rise)
  );

  byte_pair_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (wr_rise),
    .data_i     (mcu_data_i),
    .rs_i       (mcu_rs_i),
    .exit_i     (sprite_exit_i),
    .snd_busy_i (snd_busy),
    .go_o       (snd_go),
    .word_o     (pair_word),
    .word_rs_o  (pair_rs),
    .pend_o     (word_pend),
    .sprite_o   (sprite_on)
  );

  latched_word_sender #(.STEP_CYC(STEP_CYC)) u_sender (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (snd_go),
    .word_i (pair_word),
    .rs_i   (pair_rs),
    .pins_o (snd_pins),
    .busy_o (snd_busy)
  );

  assign fw_pins.data = fw_data_i;
  assign fw_pins.le   = fw_le_i;
  assign fw_pins.wr_n = fw_wr_n_i;
  assign fw_pins.rs   = fw_rs_i;

  // Hand the pins over only when no passthrough word is in flight or waiting
  assign sel_fw = sprite_on & ~snd_busy & ~word_pend;

  lcd_bus_mux u_mux (
    .sel_fw_i (sel_fw),
    .pt_i     (snd_pins),
    .fw_i     (fw_pins),
    .pins_o   (out_pins)
  );

  assign lcd_data_o    = out_pins.data;
  assign lcd_le_o      = out_pins.le;
  assign lcd_wr_n_o    = out_pins.wr_n;
  assign lcd_rs_o      = out_pins.rs;
  assign fw_grant_o    = sel_fw;
  assign sprite_mode_o = sprite_on;
  assign mcu_busy_o    = word_pend | snd_busy | (sprite_on & fw_active_i);

  AST_GRANT_NEEDS_IDLE_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
    fw_grant_o |-> !snd_busy); // R9

  AST_BUSY_COVERS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    word_pend |-> mcu_busy_o); // R7

  AST_SEND_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snd_busy) |-> $past(word_pend)); // R8

endmodule

// File: tb/test_lcd_passthru_bridge.sv
`timescale 1ns/1ps
module test_lcd_passthru_bridge;

  localparam int STEP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mcu_data = '0;
  logic       mcu_wr = 1'b0;
  logic       mcu_rs = 1'b0;
  logic       mcu_busy;
  logic       sprite_mode;
  logic       sprite_exit = 1'b0;
  logic       fw_active = 1'b0;
  logic       fw_grant;
  logic [7:0] fw_data = 8'hC3;
  logic       fw_le = 1'b0;
  logic       fw_wr_n = 1'b1;
  logic       fw_rs = 1'b1;
  logic [7:0] lcd_data;
  logic       lcd_le;
  logic       lcd_wr_n;
  logic       lcd_rs;

  always #2.5 clk = ~clk;

  lcd_passthru_bridge #(.STEP_CYC(STEP)) i_lcd_passthru_bridge (
    .clk(clk), .rst_n(rst_n),
    .mcu_data_i(mcu_data), .mcu_wr_i(mcu_wr), .mcu_rs_i(mcu_rs),
    .mcu_busy_o(mcu_busy), .sprite_mode_o(sprite_mode), .sprite_exit_i(sprite_exit),
    .fw_active_i(fw_active), .fw_grant_o(fw_grant),
    .fw_data_i(fw_data), .fw_le_i(fw_le), .fw_wr_n_i(fw_wr_n), .fw_rs_i(fw_rs),
    .lcd_data_o(lcd_data), .lcd_le_o(lcd_le), .lcd_wr_n_o(lcd_wr_n), .lcd_rs_o(lcd_rs)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  int    exp_q[$];     // {rs, word} expected at the panel
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One microcontroller write: strobe high two cycles, low two cycles
  task automatic xfer(input logic [7:0] b, input logic rs);
    @(negedge clk);
    mcu_data = b;
    mcu_rs   = rs;
    mcu_wr   = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mcu_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Send a pair and register the panel word it must produce
  task automatic send_pair(input logic [7:0] f, input logic frs,
                           input logic [7:0] s, input logic srs, input string req);
    int w;
    xfer(f, frs);
    xfer(s, srs);
    w = ((int'(f) & 'h7F) << 9) | (int'(s) << 1);
    exp_q.push_back((int'(frs) << 16) | w);
    tag_q.push_back(req);
  endtask

  // Monitor: rebuild panel words from the latch and write strobes
  logic [7:0] hi_b;
  logic       prev_le = 1'b0;
  logic       prev_wr_n = 1'b1;
  int         le_cnt = 0;
  int         wr_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_le) le_cnt++;
      if (!lcd_wr_n) wr_cnt++;
      if (prev_le && !lcd_le) begin
        hi_b = lcd_data;
        chk(le_cnt == STEP, "R6", "latch-enable width", le_cnt, STEP);
        le_cnt = 0;
      end
      if (!prev_wr_n && lcd_wr_n) begin
        int got;
        got = (int'(lcd_rs) << 16) | (int'(hi_b) << 8) | int'(lcd_data);
        chk(wr_cnt == STEP, "R6", "write-strobe width", wr_cnt, STEP);
        wr_cnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected panel word", got, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, "panel word {rs,word}", got, e);
        end
      end
      prev_le   = lcd_le;
      prev_wr_n = lcd_wr_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mcu_busy == 1'b0, "R1", "busy after reset", mcu_busy, 0);
    chk(sprite_mode == 1'b0, "R1", "mode after reset", sprite_mode, 0);
    chk(fw_grant == 1'b0, "R1", "grant after reset", fw_grant, 0);
    chk(lcd_wr_n == 1'b1 && lcd_le == 1'b0, "R1", "idle strobes {le,wr_n}",
        {lcd_le, lcd_wr_n}, 1);

    // R2 packing with distinct patterns, R7 busy window
    send_pair(8'h00, 1'b0, 8'h00, 1'b0, "R2");
    chk(mcu_busy == 1'b1, "R7", "busy after second byte", mcu_busy, 1);
    repeat (4*STEP) @(negedge clk);
    chk(mcu_busy == 1'b0, "R7", "busy after word done", mcu_busy, 0);

    send_pair(8'h7F, 1'b1, 8'hFF, 1'b0, "R3");   // RS from first byte
    repeat (4*STEP) @(negedge clk);
    send_pair(8'h55, 1'b0, 8'hAA, 1'b1, "R3");   // second byte RS ignored
    repeat (4*STEP) @(negedge clk);
    send_pair(8'h2A, 1'b1, 8'h0F, 1'b1, "R2");
    repeat (4*STEP) @(negedge clk);

    // R4 second byte with top bit set is plain data
    send_pair(8'h12, 1'b0, 8'h80, 1'b0, "R4");
    chk(sprite_mode == 1'b0, "R4", "mode after 0x80 second byte", sprite_mode, 0);
    repeat (4*STEP + 2) @(negedge clk);

    // R8 back-to-back pairs, one stray strobe while a word waits
    send_pair(8'h01, 1'b0, 8'h23, 1'b0, "R8");
    send_pair(8'h45, 1'b1, 8'h67, 1'b0, "R8");
    xfer(8'h33, 1'b0);                            // must be dropped
    repeat (10*STEP) @(negedge clk);
    chk(mcu_busy == 1'b0, "R8", "busy after queued word", mcu_busy, 0);
    send_pair(8'h3C, 1'b0, 8'h96, 1'b1, "R8");
    repeat (4*STEP + 2) @(negedge clk);

    // R5 / R9 escape while a word is in flight
    send_pair(8'h66, 1'b1, 8'h99, 1'b0, "R9");
    xfer(8'h80, 1'b0);
    chk(sprite_mode == 1'b1, "R5", "mode after escape byte", sprite_mode, 1);
    chk(fw_grant == 1'b0, "R9", "grant while word in flight", fw_grant, 0);
    repeat (4*STEP) @(negedge clk);
    chk(fw_grant == 1'b1, "R9", "grant after word done", fw_grant, 1);
    chk(lcd_data == fw_data && lcd_rs == fw_rs, "R9", "pins follow streamer",
        lcd_data, fw_data);

    // R10 sprite mode: busy from streamer, strobes ignored
    chk(mcu_busy == 1'b0, "R10", "busy with streamer idle", mcu_busy, 0);
    fw_active = 1'b1;
    @(negedge clk);
    chk(mcu_busy == 1'b1, "R10", "busy with streamer active", mcu_busy, 1);
    fw_active = 1'b0;
    xfer(8'h11, 1'b0);
    xfer(8'h22, 1'b1);
    fw_data = 8'h5A;
    @(negedge clk);
    chk(sprite_mode == 1'b1, "R10", "mode after ignored writes", sprite_mode, 1);
    chk(lcd_data == 8'h5A, "R10", "pins still streamer", lcd_data, 8'h5A);

    // R11 exit and fresh pair
    sprite_exit = 1'b1;
    @(negedge clk);
    sprite_exit = 1'b0;
    @(negedge clk);
    chk(sprite_mode == 1'b0, "R11", "mode after exit", sprite_mode, 0);
    chk(fw_grant == 1'b0 && lcd_wr_n == 1'b1 && lcd_data == 8'h00, "R11",
        "idle pins after exit", lcd_data, 0);
    send_pair(8'h4E, 1'b1, 8'hB1, 1'b0, "R11");
    repeat (4*STEP + 4) @(negedge clk);

    chk(exp_q.size() == 0, "R5", "words still missing", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule